// File: doc/BRIEF.md
# Dual-Rail Power Sequencing Controller

This block orders the start-up and shutdown of two step-down regulator channels and produces a power-good reset flag for downstream logic. It works purely on one-bit comparator results that the analog front end has already digitized, plus a switching-cycle tick that paces every delay. The regulation loop, gate drive and thresholds themselves live outside the block.

On start-up the controller waits until both rail outputs have collapsed to near zero, the enable and input-supply comparators agree, and no over-temperature is flagged. It then counts a fixed number of switching cycles before enabling channel 1, and a second fixed delay after channel 1 reaches its rising power-good level before enabling channel 2. Shutdown runs in the opposite order: channel 2 is switched off first and put into discharge (energy feedback) mode, and channel 1 stays regulated until channel 2 reports near zero, after which channel 1 discharges. The reset flag rises only once both rails are good and the longer of an internal cycle count and an optional external delay has elapsed.

All comparator inputs pass through a two-flop synchronizer; the switching-cycle tick is taken as already aligned to the clock. Control inputs and outputs are plain levels with no handshake.

Top module: `rail_seq_ctrl`

## Requirements
- R1: While rst_n is low, rail_en, rail_fb, ss_active, por and pwr_warn_n are all 0.
- R2: Channel 1 (rail_en[0]) is enabled only after en_ok, pwr_ok, rail_zero[0], rail_zero[1] are all 1 and ot_flag is 0, continuously for CH1_DLY (128) cycle ticks; if any of them is missing it stays off.
- R3: Channel 2 (rail_en[1]) is enabled CH2_DLY (256) ticks after pg_rise[0] is seen in the channel-1 start phase, and only while vmon_ok is 1; channel 2 is never on without channel 1.
- R4: When vmon_ok drops with both channels on, rail_en[1] clears and rail_fb[1] sets while channel 1 stays on; once rail_zero[1] is 1, rail_en[0] clears and rail_fb[0] sets. Channel 1 enters discharge only from the channel-2 discharge phase.
- R5: After channel 1 reports rail_zero[0], the start-up sequence is re-run; a stalled channel 2 start (delay expired, vmon_ok low) completes within a few clocks once vmon_ok returns.
- R6: por rises only when both pg_rise bits and both pg_hold bits are 1 in the running state and POR_DLY (512) ticks have passed with both pg_rise high, and, if ext_dly_en is 1, ext_dly_done is also 1.
- R7: With ext_dly_en at 0, ext_dly_done is ignored and por depends only on the internal count.
- R8: por drops within three clocks when either pg_hold bit goes to 0, while both channels stay enabled.
- R9: ot_flag at 1 drives pwr_warn_n to 0 and runs the shutdown sequence of R4; when ot_flag clears, start-up of R2 runs again. pwr_warn_n is pwr_ok AND NOT ot_flag.
- R10: en_ok at 0 turns off rail_en and rail_fb within three clocks and clears all sequencing state.
- R11: ss_active[i] is 1 for SS_CYC (512) ticks after rail_en[i] rises and 0 after that.
- R12: All delays count cyc_tick pulses, not clock cycles.
- R13: A channel is never enabled and in discharge mode at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick | input | 1 | One-clock pulse per switching cycle |
| en_ok | input | 1 | Enable comparator above threshold |
| pwr_ok | input | 1 | Input-supply comparator above threshold |
| vmon_ok | input | 1 | Voltage-monitor comparator (hysteretic) above threshold |
| ot_flag | input | 1 | Over-temperature detected |
| ext_dly_en | input | 1 | External reset delay in use (0 when not fitted) |
| ext_dly_done | input | 1 | External reset delay has elapsed |
| rail_zero | input | 2 | Per rail, output below near-zero level (bit 0 = channel 1) |
| pg_rise | input | 2 | Per rail, output above rising power-good level |
| pg_hold | input | 2 | Per rail, output above falling power-good level |
| rail_en | output | 2 | Per channel regulator enable |
| rail_fb | output | 2 | Per channel discharge / energy feedback mode |
| ss_active | output | 2 | Per channel soft-start window active |
| pwr_warn_n | output | 1 | Power-fail warning, low when asserted |
| por | output | 1 | Power-on reset flag, high when both rails good |

## Verification
The hardest state to reach is a channel-2 start that is held back after its delay has already run out: it needs a full shutdown driven by the voltage monitor, channel 2 and then channel 1 reporting near zero, a restart of channel 1 with the monitor still low, and a wait beyond the channel-2 delay. The stimulus table walks that path step by step and then raises the monitor, expecting channel 2 within a few clocks rather than after another full delay. The external reset delay being the longer one is reached by holding the done flag low well past the internal count.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_READY,
    ST_CH1_UP,
    ST_CH2_WAIT,
    ST_RUN,
    ST_CH2_DOWN,
    ST_CH1_DOWN
  } seq_state_e;
endpackage

// File: rtl/seq_sync.sv
module seq_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
#(
  parameter int CH1_DLY = 128,
  parameter int CH2_DLY = 256,
  parameter int CW      = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic       pwr,
  input  logic       vmon,
  input  logic       ot,
  input  logic [1:0] zero,
  input  logic       rise1,
  output seq_state_e state,
  output logic [1:0] rail_en,
  output logic [1:0] rail_fb
);
  seq_state_e nxt;
  logic [CW-1:0] cnt, cnt_n;
  logic ready;

  assign ready = en & pwr & ~ot & (&zero);

  always_comb begin
    nxt   = state;
    cnt_n = cnt;
    if (!en) begin
      nxt   = ST_OFF;
      cnt_n = '0;
    end else begin
      case (state)
        ST_OFF: begin
          nxt   = ST_WAIT_READY;
          cnt_n = '0;
        end
        ST_WAIT_READY: begin
          if (!ready) cnt_n = '0;
          else if (cnt == CW'(CH1_DLY)) begin
            nxt   = ST_CH1_UP;
            cnt_n = '0;
          end else if (tick) cnt_n = cnt + 1'b1;
        end
        ST_CH1_UP: begin
          if (ot) nxt = ST_CH2_DOWN;
          else if (rise1) begin
            nxt   = ST_CH2_WAIT;
            cnt_n = '0;
          end
        end
        ST_CH2_WAIT: begin
          if (ot) nxt = ST_CH2_DOWN;
          else if (cnt == CW'(CH2_DLY)) begin
            if (vmon) nxt = ST_RUN;
          end else if (tick) cnt_n = cnt + 1'b1;
        end
        ST_RUN: begin
          if (ot || !vmon) nxt = ST_CH2_DOWN;
        end
        ST_CH2_DOWN: begin
          if (zero[1]) nxt = ST_CH1_DOWN;
        end
        ST_CH1_DOWN: begin
          if (zero[0]) begin
            nxt   = ST_WAIT_READY;
            cnt_n = '0;
          end
        end
        default: nxt = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OFF;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= cnt_n;
    end
  end

  always_comb begin
    rail_en = 2'b00;
    rail_fb = 2'b00;
    case (state)
      ST_CH1_UP, ST_CH2_WAIT: rail_en = 2'b01;
      ST_RUN:                 rail_en = 2'b11;
      ST_CH2_DOWN: begin
        rail_en = 2'b01;
        rail_fb = 2'b10;
      end
      ST_CH1_DOWN:            rail_fb = 2'b01;
      default: ;
    endcase
  end
endmodule

// File: rtl/seq_por.sv
module seq_por #(
  parameter int POR_DLY = 512,
  parameter int CW      = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       run,
  input  logic [1:0] rise,
  input  logic [1:0] hold,
  input  logic       xen,
  input  logic       xdone,
  output logic       por
);
  logic [CW-1:0] cnt;
  logic por_q, int_done, ext_done;

  assign int_done = (cnt == CW'(POR_DLY));
  assign ext_done = ~xen | xdone;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      por_q <= 1'b0;
    end else begin
      if (!run || !(&rise)) cnt <= '0;
      else if (tick && !int_done) cnt <= cnt + 1'b1;

      if (!run || !(&hold)) por_q <= 1'b0;
      else if ((&rise) && int_done && ext_done) por_q <= 1'b1;
    end
  end

  assign por = por_q & run;
endmodule

// File: rtl/seq_softstart.sv
module seq_softstart #(
  parameter int SS_CYC = 512,
  parameter int CW     = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!en) cnt <= '0;
    else if (tick && cnt != CW'(SS_CYC)) cnt <= cnt + 1'b1;
  end

  assign busy = en & (cnt != CW'(SS_CYC));
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
  import seq_pkg::*;
#(
  parameter int CH1_DLY = 128,
  parameter int CH2_DLY = 256,
  parameter int POR_DLY = 512,
  parameter int SS_CYC  = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_tick,
  input  logic       en_ok,
  input  logic       pwr_ok,
  input  logic       vmon_ok,
  input  logic       ot_flag,
  input  logic       ext_dly_en,
  input  logic       ext_dly_done,
  input  logic [1:0] rail_zero,
  input  logic [1:0] pg_rise,
  input  logic [1:0] pg_hold,
  output logic [1:0] rail_en,
  output logic [1:0] rail_fb,
  output logic [1:0] ss_active,
  output logic       pwr_warn_n,
  output logic       por
);
  localparam int MAX_A = (CH1_DLY > CH2_DLY) ? CH1_DLY : CH2_DLY;
  localparam int MAX_B = (POR_DLY > SS_CYC) ? POR_DLY : SS_CYC;
  localparam int MAXD  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXD + 1);
  localparam int NIN   = 12;

  logic [NIN-1:0] raw, syn;
  logic en_s, pwr_s, vmon_s, ot_s, xen_s, xdone_s;
  logic [1:0] zero_s, rise_s, hold_s;
  seq_state_e state;

  assign raw = {en_ok, pwr_ok, vmon_ok, ot_flag, ext_dly_en, ext_dly_done,
                rail_zero, pg_rise, pg_hold};

  seq_sync #(.W(NIN)) u_sync (.clk(clk), .rst_n(rst_n), .d(raw), .q(syn));

  assign {en_s, pwr_s, vmon_s, ot_s, xen_s, xdone_s, zero_s, rise_s, hold_s} = syn;

  seq_fsm #(.CH1_DLY(CH1_DLY), .CH2_DLY(CH2_DLY), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(cyc_tick),
    .en(en_s), .pwr(pwr_s), .vmon(vmon_s), .ot(ot_s),
    .zero(zero_s), .rise1(rise_s[0]),
    .state(state), .rail_en(rail_en), .rail_fb(rail_fb)
  );

  seq_por #(.POR_DLY(POR_DLY), .CW(CW)) u_por (
    .clk(clk), .rst_n(rst_n), .tick(cyc_tick),
    .run(state == ST_RUN), .rise(rise_s), .hold(hold_s),
    .xen(xen_s), .xdone(xdone_s), .por(por)
  );

  for (genvar i = 0; i < 2; i++) begin : g_ss
    seq_softstart #(.SS_CYC(SS_CYC), .CW(CW)) u_ss (
      .clk(clk), .rst_n(rst_n), .tick(cyc_tick),
      .en(rail_en[i]), .busy(ss_active[i])
    );
  end

  assign pwr_warn_n = pwr_s & ~ot_s;
endmodule

// File: rtl/rail_seq_ctrl_chk.sv
module rail_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_ok,
  input logic       ot_flag,
  input logic [1:0] pg_hold,
  input logic [1:0] rail_en,
  input logic [1:0] rail_fb,
  input logic       pwr_warn_n,
  input logic       por
);
  assert_fb_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en & rail_fb) == 2'b00);

  assert_ch2_needs_ch1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rail_en[1] |-> rail_en[0]);

  assert_ch1_dis_after_ch2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_fb[0]) |-> $past(rail_fb[1]));

  assert_por_both_on_R6: assert property (@(posedge clk) disable iff (!rst_n)
    por |-> rail_en == 2'b11);

  assert_por_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(&$past(pg_hold, 3)) |-> !por);

  assert_warn_ot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ot_flag, 2) |-> !pwr_warn_n);

  assert_en_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en_ok, 3) |-> (rail_en == 2'b00 && rail_fb == 2'b00));
endmodule

bind rail_seq_ctrl rail_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_ok(en_ok), .ot_flag(ot_flag),
  .pg_hold(pg_hold), .rail_en(rail_en), .rail_fb(rail_fb),
  .pwr_warn_n(pwr_warn_n), .por(por)
);

// File: tb/rail_seq_ctrl_tb.sv
module rail_seq_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int NSTEP = 13;
  // stimulus {en,pwr,vmon,ot,xen,xdone,zero[1:0],rise[1:0],hold[1:0]}, wait, expect {en[1:0],fb[1:0],por,warn_n}
  localparam logic [33:0] TBL [NSTEP] = '{
    {12'b111000110000, 16'd200, 6'b010001},
    {12'b111000100101, 16'd300, 6'b110001},
    {12'b111000001111, 16'd600, 6'b110011},
    {12'b110000001111, 16'd10,  6'b011001},
    {12'b110000100101, 16'd10,  6'b000101},
    {12'b110000110000, 16'd200, 6'b010001},
    {12'b110000100101, 16'd400, 6'b010001},
    {12'b111000100101, 16'd10,  6'b110001},
    {12'b111100001111, 16'd10,  6'b011000},
    {12'b111100100101, 16'd10,  6'b000100},
    {12'b111100110000, 16'd300, 6'b000000},
    {12'b111000110000, 16'd200, 6'b010001},
    {12'b011000110000, 16'd5,   6'b000001}
  };

  logic clk = 1'b0, rst_n = 1'b0, cyc_tick = 1'b1;
  logic en_ok, pwr_ok, vmon_ok, ot_flag, ext_dly_en, ext_dly_done;
  logic [1:0] rail_zero, pg_rise, pg_hold;
  logic [1:0] rail_en, rail_fb, ss_active;
  logic pwr_warn_n, por;
  logic slow = 1'b0;
  logic [1:0] div = 2'd0;
  int n_tests = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) begin
    div      <= div + 2'd1;
    cyc_tick <= slow ? (div == 2'd0) : 1'b1;
  end

  rail_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .en_ok(en_ok),
    .pwr_ok(pwr_ok), .vmon_ok(vmon_ok), .ot_flag(ot_flag),
    .ext_dly_en(ext_dly_en), .ext_dly_done(ext_dly_done),
    .rail_zero(rail_zero), .pg_rise(pg_rise), .pg_hold(pg_hold),
    .rail_en(rail_en), .rail_fb(rail_fb), .ss_active(ss_active),
    .pwr_warn_n(pwr_warn_n), .por(por)
  );

  task automatic apply(input logic [11:0] s);
    {en_ok, pwr_ok, vmon_ok, ot_flag, ext_dly_en, ext_dly_done,
     rail_zero, pg_rise, pg_hold} = s;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic string step_req(input int i);
    case (i)
      0: return "R2 ch1 start";
      1: return "R3 ch2 start";
      2: return "R7 por internal only";
      3, 4: return "R4 reverse shutdown";
      5, 6, 7: return "R5 restart and rearm";
      8, 9, 10, 11: return "R9 over-temperature";
      default: return "R10 enable off";
    endcase
  endfunction

  task automatic do_reset;
    rst_n = 1'b0;
    apply(12'b0);
    waitn(3);
    check("R1 reset outputs", {1'b0, rail_en, rail_fb, ss_active, por},
          8'b0);
    check("R1 reset warn", {7'b0, pwr_warn_n}, 8'b0);
    rst_n = 1'b1;
    waitn(2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < NSTEP; i++) begin
      apply(TBL[i][33:22]);
      waitn(int'(TBL[i][21:6]));
      check(step_req(i), {2'b0, rail_en, rail_fb, por, pwr_warn_n},
            {2'b0, TBL[i][5:0]});
    end

    // R2 gating and timing window, R11 soft start
    do_reset();
    apply(12'b111000100000);
    waitn(300);
    check("R2 ch1 held while ch1 not zero", {6'b0, rail_en}, 8'd0);
    apply(12'b111000110000);
    waitn(100);
    check("R2 ch1 not before 128 ticks", {6'b0, rail_en}, 8'd0);
    waitn(40);
    check("R2 ch1 after 128 ticks", {6'b0, rail_en}, 8'd1);
    check("R11 ch1 soft start active", {7'b0, ss_active[0]}, 8'd1);
    apply(12'b111000100101);
    waitn(240);
    check("R3 ch2 not before 256 ticks", {6'b0, rail_en}, 8'd1);
    waitn(40);
    check("R3 ch2 after 256 ticks", {6'b0, rail_en}, 8'd3);
    waitn(250);
    check("R11 ch1 soft start over", {6'b0, ss_active}, 8'b10);

    // R6 external delay longer than internal
    apply(12'b111010001111);
    waitn(700);
    check("R6 por waits for external delay", {7'b0, por}, 8'd0);
    apply(12'b111011001111);
    waitn(5);
    check("R6 por after external delay", {7'b0, por}, 8'd1);

    // R8 falling power-good drops por
    apply(12'b111011001110);
    waitn(5);
    check("R8 por drops", {7'b0, por}, 8'd0);
    check("R8 rails stay on", {6'b0, rail_en}, 8'd3);

    // R6 internal count governs when external done early
    apply(12'b111011001011);
    waitn(5);
    apply(12'b111011001111);
    waitn(400);
    check("R6 por not before internal count", {7'b0, por}, 8'd0);
    waitn(130);
    check("R6 por after internal count", {7'b0, por}, 8'd1);

    // R12 delays count ticks, not clocks
    do_reset();
    slow = 1'b1;
    apply(12'b111000110000);
    waitn(400);
    check("R12 ch1 waits for ticks", {6'b0, rail_en}, 8'd0);
    waitn(150);
    check("R12 ch1 after 128 ticks", {6'b0, rail_en}, 8'd1);
    slow = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule